// File: doc/BRIEF.md
# Bus Debug Trigger Unit

This unit watches the two buses of a processor, the instruction fetch bus and the data access bus, and compares every valid bus cycle against four programmable comparators. When a comparator's conditions all hold, its selected actions fire. An action can request a halt, pulse an external trigger line, switch trace collection on or off, take a single trace sample, or arm the dependent triggers. Software programs the comparators through a simple register-write port.

Each comparator can test the cycle's address, its data value, or both, and the tests are ANDed. On the data bus a comparator can also require a read or a write cycle, wait for the arm flag, or join with its odd neighbour to test an inclusive unsigned range. Conditions are evaluated in the cycle the bus valid strobe is high. Every action output is registered, so it appears one clock after the matching bus cycle.

Three small state machines hold the unit's state. The arm machine has the states ARM_OFF and ARM_ON: an arm action moves it to ARM_ON, and a clear command without an arm action in the same cycle moves it back. The trace machine has TR_OFF and TR_ON: a trace-on action without a trace-off moves it to TR_ON, and a trace-off moves it back. The halt machine has HS_RUN and HS_PEND: a halt action moves it to HS_PEND, and an acknowledge without a halt action in the same cycle moves it back.

Top module: `dbg_trig_unit`

## Requirements
- R1: Reset clears all comparator configuration, the arm flag, trace_en and any pending halt. While reset is held and on the first cycle after it, halt_req, ext_trig, trace_en and trace_sample are 0.
- R2: A comparator whose control bit 0 (enable) is 0 never fires an action.
- R3: Control bit 1 selects the bus (0 instruction, 1 data) and bit 2 requests an address-equality test against the comparator's value register. Comparator i's control register is at wr_addr 2*i and its value register at 2*i+1. A write takes effect from the next cycle. A match produces its action one clock after the valid bus cycle.
- R4: Control bit 3 requests a data-equality test. With both bit 2 and bit 3 set, the address and the data must both equal the value register. With neither set, any valid cycle on the selected bus matches.
- R5: On the data bus, control bit 4 limits matching to reads (db_write=0) and bit 5 limits it to writes (db_write=1). With both set, the comparator never matches. On the instruction bus, bits 4 and 5 have no effect.
- R6: Action bit 8 (halt) sets halt_req one clock after the match. halt_req then stays high until a cycle in which halt_ack is high and no halt action fires.
- R7: Action bit 9 drives ext_trig high for exactly the one cycle that follows each matching bus cycle.
- R8: Action bit 10 sets trace_en and action bit 11 clears it. trace_en holds its value between actions. When both actions fire in the same cycle, trace_en becomes 0.
- R9: Action bit 12 pulses trace_sample for one cycle, but only from comparators on the data bus. On an instruction-bus comparator this bit has no effect.
- R10: Action bit 13 sets the arm flag. A data-bus comparator with control bit 6 set can fire only on cycles after the arm flag was set. The flag stays set until reset, or until a write of 1 in bit 0 to wr_addr 2*NCMP in a cycle with no arm action. Bit 6 has no effect on the instruction bus.
- R11: Control bit 7 on an even data-bus comparator i pairs it with comparator i+1. The checked fields must then lie in the inclusive unsigned range from value(i) to value(i+1). While the pair is enabled, comparator i+1 fires none of its own actions.
- R12: When several comparators match in the same cycle, their actions combine by OR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | RAW (4) | Register address |
| wr_data | input | VW (16) | Register write data |
| ib_valid | input | 1 | Instruction bus cycle valid |
| ib_addr | input | AW (16) | Instruction bus address |
| ib_data | input | DW (16) | Instruction bus data |
| db_valid | input | 1 | Data bus cycle valid |
| db_addr | input | AW (16) | Data bus address |
| db_data | input | DW (16) | Data bus data |
| db_write | input | 1 | Data bus cycle is a write |
| halt_ack | input | 1 | Halt request acknowledge |
| halt_req | output | 1 | Sticky halt request |
| ext_trig | output | 1 | One-cycle external trigger pulse |
| trace_en | output | 1 | Trace collection enabled |
| trace_sample | output | 1 | One-cycle trace sample strobe |

## Verification
The assertions assume that the bus valid strobes and halt_ack are held at known levels outside reset. They also assume that a register write is never what alone changes an output, since every output change must follow a bus cycle. The stimulus changes inputs only on the falling clock edge and keeps register writes in cycles without bus activity. The one exception is the arm-clear command, which never coincides with an arm action in the stimulus.

// File: rtl/dtu_pkg.sv
package dtu_pkg;

    localparam int CTRL_W = 14;
    localparam int NACT   = 6;

    localparam int ACT_HALT = 0;
    localparam int ACT_EXT  = 1;
    localparam int ACT_TON  = 2;
    localparam int ACT_TOFF = 3;
    localparam int ACT_SMP  = 4;
    localparam int ACT_ARM  = 5;

    typedef struct packed {
        logic [NACT-1:0] act;
        logic            range_lo;
        logic            armed;
        logic            wr_only;
        logic            rd_only;
        logic            chk_data;
        logic            chk_addr;
        logic            dbus;
        logic            en;
    } cmp_ctrl_t;

    typedef enum logic {ARM_OFF, ARM_ON}  arm_st_t;
    typedef enum logic {TR_OFF, TR_ON}    trace_st_t;
    typedef enum logic {HS_RUN, HS_PEND}  halt_st_t;

endpackage

// File: rtl/dtu_regs.sv
module dtu_regs
    import dtu_pkg::*;
#(
    parameter int NCMP = 4,
    parameter int VW   = 16,
    parameter int RAW  = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [RAW-1:0]  wr_addr,
    input  logic [VW-1:0]   wr_data,
    output cmp_ctrl_t       ctrl_o [NCMP],
    output logic [VW-1:0]   val_o  [NCMP],
    output logic            arm_clr
);

    localparam logic [RAW-1:0] CMD_ADDR = RAW'(2 * NCMP);

    for (genvar i = 0; i < NCMP; i++) begin : g_reg
        localparam logic [RAW-1:0] CADDR = RAW'(2 * i);
        localparam logic [RAW-1:0] VADDR = RAW'(2 * i + 1);

        always_ff @(posedge clk) begin
            if (rst) begin
                ctrl_o[i] <= '0;
                val_o[i]  <= '0;
            end else if (wr_en) begin
                if (wr_addr == CADDR) ctrl_o[i] <= cmp_ctrl_t'(wr_data[CTRL_W-1:0]);
                if (wr_addr == VADDR) val_o[i]  <= wr_data;
            end
        end
    end

    assign arm_clr = wr_en && (wr_addr == CMD_ADDR) && wr_data[0];

endmodule

// File: rtl/dtu_cmp.sv
module dtu_cmp
    import dtu_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DW    = 16,
    parameter int VW    = 16,
    parameter bit IS_LO = 1'b0
) (
    input  cmp_ctrl_t        ctrl_i,
    input  logic [VW-1:0]    lo_val,
    input  logic [VW-1:0]    hi_val,
    input  logic             bound_only,
    input  logic             arm_flag,
    input  logic             ib_valid,
    input  logic [AW-1:0]    ib_addr,
    input  logic [DW-1:0]    ib_data,
    input  logic             db_valid,
    input  logic [AW-1:0]    db_addr,
    input  logic [DW-1:0]    db_data,
    input  logic             db_write,
    output logic [NACT-1:0]  fire_o
);

    logic          range_on;
    logic          cyc_v;
    logic [AW-1:0] a_op;
    logic [DW-1:0] d_op;
    logic          a_ok, d_ok, kind_ok, arm_ok, hit;
    logic [NACT-1:0] act_eff;

    always_comb begin
        range_on = IS_LO && ctrl_i.range_lo && ctrl_i.dbus;
        cyc_v    = ctrl_i.dbus ? db_valid : ib_valid;
        a_op     = ctrl_i.dbus ? db_addr  : ib_addr;
        d_op     = ctrl_i.dbus ? db_data  : ib_data;

        if (range_on) begin
            a_ok = (a_op >= lo_val[AW-1:0]) && (a_op <= hi_val[AW-1:0]);
            d_ok = (d_op >= lo_val[DW-1:0]) && (d_op <= hi_val[DW-1:0]);
        end else begin
            a_ok = (a_op == lo_val[AW-1:0]);
            d_ok = (d_op == lo_val[DW-1:0]);
        end

        kind_ok = !ctrl_i.dbus ||
                  ((!ctrl_i.rd_only || !db_write) && (!ctrl_i.wr_only || db_write));
        arm_ok  = !ctrl_i.dbus || !ctrl_i.armed || arm_flag;

        hit = ctrl_i.en && cyc_v && !bound_only && kind_ok && arm_ok &&
              (!ctrl_i.chk_addr || a_ok) && (!ctrl_i.chk_data || d_ok);

        act_eff          = ctrl_i.act;
        act_eff[ACT_SMP] = ctrl_i.act[ACT_SMP] && ctrl_i.dbus;
        fire_o           = hit ? act_eff : '0;
    end

endmodule

// File: rtl/dtu_act.sv
module dtu_act
    import dtu_pkg::*;
#(
    parameter int NCMP = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NCMP-1:0][NACT-1:0]   fire_vec,
    input  logic                        arm_clr,
    input  logic                        halt_ack,
    output logic                        arm_flag,
    output logic                        halt_req,
    output logic                        ext_trig,
    output logic                        trace_en,
    output logic                        trace_sample
);

    logic [NACT-1:0] any_fire;
    arm_st_t   arm_q, arm_d;
    trace_st_t tr_q,  tr_d;
    halt_st_t  hs_q,  hs_d;
    logic      ext_q, smp_q;

    always_comb begin
        any_fire = '0;
        for (int k = 0; k < NCMP; k++) any_fire |= fire_vec[k];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            arm_q <= ARM_OFF;
            tr_q  <= TR_OFF;
            hs_q  <= HS_RUN;
            ext_q <= 1'b0;
            smp_q <= 1'b0;
        end else begin
            arm_q <= arm_d;
            tr_q  <= tr_d;
            hs_q  <= hs_d;
            ext_q <= any_fire[ACT_EXT];
            smp_q <= any_fire[ACT_SMP];
        end
    end

    always_comb begin
        unique case (arm_q)
            ARM_OFF: arm_d = any_fire[ACT_ARM] ? ARM_ON : ARM_OFF;
            ARM_ON:  arm_d = (arm_clr && !any_fire[ACT_ARM]) ? ARM_OFF : ARM_ON;
        endcase
        unique case (tr_q)
            TR_OFF: tr_d = (any_fire[ACT_TON] && !any_fire[ACT_TOFF]) ? TR_ON : TR_OFF;
            TR_ON:  tr_d = any_fire[ACT_TOFF] ? TR_OFF : TR_ON;
        endcase
        unique case (hs_q)
            HS_RUN:  hs_d = any_fire[ACT_HALT] ? HS_PEND : HS_RUN;
            HS_PEND: hs_d = (halt_ack && !any_fire[ACT_HALT]) ? HS_RUN : HS_PEND;
        endcase
    end

    always_comb begin
        arm_flag     = (arm_q == ARM_ON);
        trace_en     = (tr_q == TR_ON);
        halt_req     = (hs_q == HS_PEND);
        ext_trig     = ext_q;
        trace_sample = smp_q;
    end

endmodule

// File: rtl/dbg_trig_unit.sv
module dbg_trig_unit
    import dtu_pkg::*;
#(
    parameter  int NCMP = 4,
    parameter  int AW   = 16,
    parameter  int DW   = 16,
    localparam int VW   = (AW > DW) ? AW : DW,
    localparam int RAW  = $clog2(NCMP) + 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [RAW-1:0]  wr_addr,
    input  logic [VW-1:0]   wr_data,
    input  logic            ib_valid,
    input  logic [AW-1:0]   ib_addr,
    input  logic [DW-1:0]   ib_data,
    input  logic            db_valid,
    input  logic [AW-1:0]   db_addr,
    input  logic [DW-1:0]   db_data,
    input  logic            db_write,
    input  logic            halt_ack,
    output logic            halt_req,
    output logic            ext_trig,
    output logic            trace_en,
    output logic            trace_sample
);

    cmp_ctrl_t  ctrl [NCMP];
    logic [VW-1:0] val [NCMP];
    logic       arm_clr;
    logic       arm_flag;
    logic [NCMP-1:0][NACT-1:0] fire_vec;

    dtu_regs #(.NCMP(NCMP), .VW(VW), .RAW(RAW)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ctrl_o  (ctrl),
        .val_o   (val),
        .arm_clr (arm_clr)
    );

    for (genvar i = 0; i < NCMP; i++) begin : g_cmp
        localparam bit LO = ((i % 2) == 0) && (i + 1 < NCMP);
        logic [VW-1:0] hi;
        logic          bnd;

        if (LO) begin : g_hi
            assign hi = val[i+1];
        end else begin : g_nohi
            assign hi = val[i];
        end

        if ((i % 2) == 1) begin : g_bnd
            assign bnd = ctrl[i-1].en && ctrl[i-1].range_lo && ctrl[i-1].dbus;
        end else begin : g_nobnd
            assign bnd = 1'b0;
        end

        dtu_cmp #(.AW(AW), .DW(DW), .VW(VW), .IS_LO(LO)) u_cmp (
            .ctrl_i     (ctrl[i]),
            .lo_val     (val[i]),
            .hi_val     (hi),
            .bound_only (bnd),
            .arm_flag   (arm_flag),
            .ib_valid   (ib_valid),
            .ib_addr    (ib_addr),
            .ib_data    (ib_data),
            .db_valid   (db_valid),
            .db_addr    (db_addr),
            .db_data    (db_data),
            .db_write   (db_write),
            .fire_o     (fire_vec[i])
        );
    end

    dtu_act #(.NCMP(NCMP)) u_act (
        .clk          (clk),
        .rst          (rst),
        .fire_vec     (fire_vec),
        .arm_clr      (arm_clr),
        .halt_ack     (halt_ack),
        .arm_flag     (arm_flag),
        .halt_req     (halt_req),
        .ext_trig     (ext_trig),
        .trace_en     (trace_en),
        .trace_sample (trace_sample)
    );

endmodule

// File: rtl/dtu_chk.sv
module dtu_chk (
    input logic clk,
    input logic rst,
    input logic ib_valid,
    input logic db_valid,
    input logic halt_ack,
    input logic halt_req,
    input logic ext_trig,
    input logic trace_en,
    input logic trace_sample
);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!halt_req && !ext_trig && !trace_en && !trace_sample));

    // R6
    halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (halt_req && !halt_ack) |=> halt_req);

    // R6
    halt_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(halt_req) |-> $past(ib_valid || db_valid));

    // R7
    ext_src_chk: assert property (@(posedge clk) disable iff (rst)
        ext_trig |-> $past(ib_valid || db_valid));

    // R9
    sample_src_chk: assert property (@(posedge clk) disable iff (rst)
        trace_sample |-> $past(db_valid));

    // R8
    trace_move_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(trace_en) |-> $past(ib_valid || db_valid));

endmodule

bind dbg_trig_unit dtu_chk u_dtu_chk (
    .clk          (clk),
    .rst          (rst),
    .ib_valid     (ib_valid),
    .db_valid     (db_valid),
    .halt_ack     (halt_ack),
    .halt_req     (halt_req),
    .ext_trig     (ext_trig),
    .trace_en     (trace_en),
    .trace_sample (trace_sample)
);

// File: tb/test_dbg_trig_unit.sv
module test_dbg_trig_unit;

    localparam logic [5:0] A_HALT = 6'b000001;
    localparam logic [5:0] A_EXT  = 6'b000010;
    localparam logic [5:0] A_TON  = 6'b000100;
    localparam logic [5:0] A_TOFF = 6'b001000;
    localparam logic [5:0] A_SMP  = 6'b010000;
    localparam logic [5:0] A_ARM  = 6'b100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        ib_valid = 1'b0;
    logic [15:0] ib_addr = '0;
    logic [15:0] ib_data = '0;
    logic        db_valid = 1'b0;
    logic [15:0] db_addr = '0;
    logic [15:0] db_data = '0;
    logic        db_write = 1'b0;
    logic        halt_ack = 1'b0;
    logic        halt_req, ext_trig, trace_en, trace_sample;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    dbg_trig_unit i_dbg_trig_unit (
        .clk (clk), .rst (rst),
        .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
        .ib_valid (ib_valid), .ib_addr (ib_addr), .ib_data (ib_data),
        .db_valid (db_valid), .db_addr (db_addr), .db_data (db_data),
        .db_write (db_write), .halt_ack (halt_ack),
        .halt_req (halt_req), .ext_trig (ext_trig),
        .trace_en (trace_en), .trace_sample (trace_sample)
    );

    function automatic logic [15:0] mk(bit en, bit dbus, bit ca, bit cd, bit rd,
                                       bit wo, bit armed, bit rng, logic [5:0] act);
        return {2'b00, act, rng, armed, wo, rd, cd, ca, dbus, en};
    endfunction

    task automatic chk(string req, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        @(negedge clk);
        @(negedge clk) rst = 1'b0;
    endtask

    task automatic wr(logic [3:0] a, logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus(bit dbus, logic [15:0] a, logic [15:0] d, bit we);
        @(negedge clk);
        if (dbus) begin
            db_valid = 1'b1; db_addr = a; db_data = d; db_write = we;
        end else begin
            ib_valid = 1'b1; ib_addr = a; ib_data = d;
        end
        @(negedge clk);
        db_valid = 1'b0; ib_valid = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    initial begin
        #(10 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        @(negedge clk); @(negedge clk);
        chk("R1 halt in reset", halt_req, 1'b0);
        rst = 1'b0;
        chk("R1 halt", halt_req, 1'b0);
        chk("R1 ext", ext_trig, 1'b0);
        chk("R1 trace", trace_en, 1'b0);
        chk("R1 sample", trace_sample, 1'b0);

        // R2 disabled comparator
        wr(4'd0, mk(0, 1, 1, 0, 0, 0, 0, 0, A_EXT));
        wr(4'd1, 16'h0040);
        bus(1, 16'h0040, 16'h0, 0);
        chk("R2 disabled", ext_trig, 1'b0);

        // R3 address match sweep on the data bus
        wr(4'd0, mk(1, 1, 1, 0, 0, 0, 0, 0, A_EXT));
        for (int a = 16'h3C; a <= 16'h44; a++) begin
            bus(1, 16'(a), 16'h0, 0);
            chk("R3 daddr", ext_trig, a == 16'h40);
        end
        bus(0, 16'h0040, 16'h0, 0);
        chk("R3 wrong bus", ext_trig, 1'b0);
        wr(4'd0, mk(1, 0, 1, 0, 0, 0, 0, 0, A_EXT));
        bus(0, 16'h0040, 16'h0, 0);
        chk("R3 iaddr", ext_trig, 1'b1);
        bus(1, 16'h0040, 16'h0, 0);
        chk("R3 ibus ignores dbus", ext_trig, 1'b0);

        // R4 data match and address AND data
        do_reset();
        wr(4'd0, mk(1, 1, 0, 1, 0, 0, 0, 0, A_EXT));
        wr(4'd1, 16'h1234);
        for (int d = 16'h1230; d <= 16'h1237; d++) begin
            bus(1, 16'h7777, 16'(d), 0);
            chk("R4 data", ext_trig, d == 16'h1234);
        end
        wr(4'd0, mk(1, 1, 1, 1, 0, 0, 0, 0, A_EXT));
        wr(4'd1, 16'h0055);
        for (int a = 16'h54; a <= 16'h55; a++) begin
            for (int d = 16'h55; d <= 16'h56; d++) begin
                bus(1, 16'(a), 16'(d), 0);
                chk("R4 and", ext_trig, (a == 16'h55) && (d == 16'h55));
            end
        end
        wr(4'd0, mk(1, 1, 0, 0, 0, 0, 0, 0, A_EXT));
        bus(1, 16'h9999, 16'h8888, 1);
        chk("R4 any cycle", ext_trig, 1'b1);

        // R5 cycle type sweep
        for (int rd = 0; rd < 2; rd++) begin
            for (int wo = 0; wo < 2; wo++) begin
                wr(4'd0, mk(1, 1, 0, 0, rd[0], wo[0], 0, 0, A_EXT));
                for (int we = 0; we < 2; we++) begin
                    bus(1, 16'h0, 16'h0, we[0]);
                    chk("R5 cycle", ext_trig, !(rd == 1 && we == 1) && !(wo == 1 && we == 0));
                end
            end
        end
        wr(4'd0, mk(1, 0, 0, 0, 1, 1, 0, 0, A_EXT));
        bus(0, 16'h0, 16'h0, 0);
        chk("R5 ibus no qual", ext_trig, 1'b1);

        // R6 halt
        do_reset();
        wr(4'd0, mk(1, 1, 1, 0, 0, 0, 0, 0, A_HALT));
        wr(4'd1, 16'h0020);
        bus(1, 16'h0020, 16'h0, 0);
        chk("R6 set", halt_req, 1'b1);
        for (int k = 0; k < 3; k++) begin
            idle();
            chk("R6 hold", halt_req, 1'b1);
        end
        @(negedge clk);
        halt_ack = 1'b1; db_valid = 1'b1; db_addr = 16'h0020;
        @(negedge clk);
        halt_ack = 1'b0; db_valid = 1'b0;
        chk("R6 ack with new halt", halt_req, 1'b1);
        @(negedge clk) halt_ack = 1'b1;
        @(negedge clk) halt_ack = 1'b0;
        chk("R6 ack", halt_req, 1'b0);

        // R7 external trigger pulse
        wr(4'd2, mk(1, 1, 1, 0, 0, 0, 0, 0, A_EXT));
        wr(4'd3, 16'h0021);
        bus(1, 16'h0021, 16'h0, 0);
        chk("R7 pulse", ext_trig, 1'b1);
        idle();
        chk("R7 one cycle", ext_trig, 1'b0);
        bus(1, 16'h0021, 16'h0, 0);
        chk("R7 again", ext_trig, 1'b1);
        bus(1, 16'h0021, 16'h0, 0);
        chk("R7 back to back", ext_trig, 1'b1);

        // R8 trace on and off
        do_reset();
        wr(4'd0, mk(1, 1, 1, 0, 0, 0, 0, 0, A_TON));  wr(4'd1, 16'h0010);
        wr(4'd2, mk(1, 1, 1, 0, 0, 0, 0, 0, A_TOFF)); wr(4'd3, 16'h0011);
        wr(4'd4, mk(1, 1, 1, 0, 0, 0, 0, 0, A_TON));  wr(4'd5, 16'h0012);
        wr(4'd6, mk(1, 1, 1, 0, 0, 0, 0, 0, A_TOFF)); wr(4'd7, 16'h0012);
        bus(1, 16'h0010, 16'h0, 0);
        chk("R8 on", trace_en, 1'b1);
        idle(); idle();
        chk("R8 hold", trace_en, 1'b1);
        bus(1, 16'h0012, 16'h0, 0);
        chk("R8 off wins", trace_en, 1'b0);
        bus(1, 16'h0010, 16'h0, 0);
        chk("R8 on again", trace_en, 1'b1);
        bus(1, 16'h0011, 16'h0, 0);
        chk("R8 off", trace_en, 1'b0);
        bus(1, 16'h0012, 16'h0, 0);
        chk("R8 both while off", trace_en, 1'b0);

        // R9 trace sample
        do_reset();
        wr(4'd0, mk(1, 1, 1, 0, 0, 0, 0, 0, A_SMP)); wr(4'd1, 16'h0030);
        wr(4'd2, mk(1, 0, 1, 0, 0, 0, 0, 0, A_SMP)); wr(4'd3, 16'h0030);
        bus(1, 16'h0030, 16'h0, 0);
        chk("R9 sample", trace_sample, 1'b1);
        idle();
        chk("R9 one cycle", trace_sample, 1'b0);
        bus(0, 16'h0030, 16'h0, 0);
        chk("R9 ibus no sample", trace_sample, 1'b0);

        // R10 armed triggers
        do_reset();
        wr(4'd0, mk(1, 1, 1, 0, 0, 0, 0, 0, A_ARM)); wr(4'd1, 16'h00A0);
        wr(4'd2, mk(1, 1, 1, 0, 0, 0, 1, 0, A_EXT)); wr(4'd3, 16'h00B0);
        bus(1, 16'h00B0, 16'h0, 0);
        chk("R10 before arm", ext_trig, 1'b0);
        bus(1, 16'h00A0, 16'h0, 0);
        chk("R10 arm event", ext_trig, 1'b0);
        bus(1, 16'h00B0, 16'h0, 0);
        chk("R10 after arm", ext_trig, 1'b1);
        bus(1, 16'h00B0, 16'h0, 0);
        chk("R10 stays armed", ext_trig, 1'b1);
        wr(4'd8, 16'h0001);
        bus(1, 16'h00B0, 16'h0, 0);
        chk("R10 cleared", ext_trig, 1'b0);
        wr(4'd4, mk(1, 0, 1, 0, 0, 0, 1, 0, A_EXT)); wr(4'd5, 16'h00C0);
        bus(0, 16'h00C0, 16'h0, 0);
        chk("R10 ibus ignores armed", ext_trig, 1'b1);
        bus(1, 16'h00A0, 16'h0, 0);
        do_reset();
        wr(4'd2, mk(1, 1, 1, 0, 0, 0, 1, 0, A_EXT)); wr(4'd3, 16'h00B0);
        bus(1, 16'h00B0, 16'h0, 0);
        chk("R10 reset disarms", ext_trig, 1'b0);

        // R11 range pair
        do_reset();
        wr(4'd0, mk(1, 1, 1, 0, 0, 0, 0, 1, A_EXT));  wr(4'd1, 16'h0100);
        wr(4'd2, mk(1, 1, 1, 0, 0, 0, 0, 0, A_HALT)); wr(4'd3, 16'h010F);
        for (int a = 16'hFC; a <= 16'h112; a++) begin
            bus(1, 16'(a), 16'h0, 0);
            chk("R11 range", ext_trig, (a >= 16'h100) && (a <= 16'h10F));
        end
        chk("R11 upper bound silent", halt_req, 1'b0);
        wr(4'd0, mk(1, 1, 0, 1, 0, 0, 0, 1, A_EXT));
        bus(1, 16'h0, 16'h0108, 0);
        chk("R11 data inside", ext_trig, 1'b1);
        bus(1, 16'h0, 16'h0110, 0);
        chk("R11 data outside", ext_trig, 1'b0);

        // R12 OR of actions
        do_reset();
        wr(4'd0, mk(1, 1, 1, 0, 0, 0, 0, 0, A_EXT));  wr(4'd1, 16'h0050);
        wr(4'd2, mk(1, 1, 1, 0, 0, 0, 0, 0, A_HALT)); wr(4'd3, 16'h0050);
        wr(4'd4, mk(1, 1, 1, 0, 0, 0, 0, 0, A_EXT));  wr(4'd5, 16'h0050);
        bus(1, 16'h0050, 16'h0, 1);
        chk("R12 ext", ext_trig, 1'b1);
        chk("R12 halt", halt_req, 1'b1);
        idle();
        chk("R12 single pulse", ext_trig, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule